// File: doc/BRIEF.md
# Serial Flash Memory-Mapped Read Sequencer

This block turns one word-read request from a processor-side bus into a complete read transaction on a serial flash. Each transaction runs four phases. An 8-bit opcode goes out on one line. A 24-bit address follows. Then comes a dummy phase of programmable length. Last, a 32-bit data phase reads the word. The address, dummy and data phases each pick their own width of one, two or four data lines.

During the opening clocks of the dummy phase the sequencer can keep driving the data lines with all ones for a programmable count. It then releases them so that the flash can turn the bus around. When the last data bit has been sampled, chip select is released, a one-cycle done strobe is raised and the assembled word is presented. The configuration fields are plain input ports. They are captured when a request is accepted. A request with an inconsistent configuration is refused with an error strobe.

Top module: `qspi_rd_seq`

## Requirements
- R1: A request whose configuration is invalid raises `cfg_err` for exactly one cycle on the cycle after the request, and starts no transaction (`cs_n` stays 1, `sck` stays 0). The configuration is invalid if `dum_len` is 0, if `drv_len` is greater than `dum_len`, or if any mode field equals 3.
- R2: `sck` is 0 whenever `cs_n` is 1 (SPI mode 0). On the cycle after an accepted request `cs_n` is 0 and `sck` is still 0, and `sck` rises on the cycle after that. While `cs_n` stays low, `sck` toggles on every system clock, so one serial clock spans two system clocks.
- R3: The first 8 serial clocks carry `opcode` on line 0, most significant bit first. During them line 0 is output-enabled and line 1 is not.
- R4: The address takes 24, 12 or 6 serial clocks for `adr_mode` 0 (single), 1 (dual) or 2 (quad). It is sent most significant bit first, on line 0, on lines 1..0 or on lines 3..0, with the higher-numbered line carrying the more significant bit. All lines in use are output-enabled.
- R5: The dummy phase lasts `dum_len`+1 serial clocks. The whole transaction lasts 8 + 24/La + (`dum_len`+1) + 32/Ld serial clocks, where La and Ld are the line counts of the address and data modes.
- R6: In the first `drv_len`+1 dummy clocks, the lines of the dummy mode (line 0; lines 1..0; lines 3..0) are output-enabled and driven with 1. In the rest of the dummy clocks those lines are not output-enabled.
- R7: The data phase samples 32 bits on the rising edge of `sck`, most significant chunk first. Single mode reads line 1. Dual mode reads lines 1..0 and quad mode reads lines 3..0, with the higher line holding the more significant bit. Lines 1..0 (and lines 3..2 in quad) are not output-enabled. The word appears on `rdata`.
- R8: Whenever the current phase is not a quad phase (idle, the command phase, or an address, dummy or data phase in mode 0 or 1), `dq_oe[3:2]` and `dq_out[3:2]` are both 2'b11.
- R9: `done` is high for exactly one cycle. In that cycle `cs_n` has just returned to 1 and `rdata` holds the word read.
- R10: The configuration, opcode and address are captured when a request is accepted. Changes to them afterwards, and `req` pulses during a transaction, have no effect on the transaction in progress and start no further one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, taken when idle |
| opcode | input | 8 | Read command byte |
| addr | input | 24 | Flash byte address |
| dum_len | input | 4 | Dummy clocks minus one (0 invalid) |
| drv_len | input | 4 | Driven dummy clocks minus one |
| adr_mode | input | 2 | Address line width: 0 single, 1 dual, 2 quad |
| dum_mode | input | 2 | Dummy line width: 0 single, 1 dual, 2 quad |
| dat_mode | input | 2 | Data line width: 0 single, 1 dual, 2 quad |
| dq_in | input | 4 | Data line input values |
| cfg_err | output | 1 | One-cycle strobe for a refused request |
| done | output | 1 | One-cycle strobe at end of read |
| rdata | output | 32 | Assembled read word |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| dq_out | output | 4 | Data line output values |
| dq_oe | output | 4 | Per-line output enable |

## Verification
The properties take for granted that `req` is only a request signal and that the flash side never needs `cs_n` held between words. Their claims about line 3..2 ownership rely on the mode values captured at acceptance. A reserved mode can never be captured, because R1 refuses it, so the properties never meet one. The stimulus draws random dummy lengths in 1..15 with drive lengths in 0..`dum_len`, and random modes in 0..2. It adds directed extremes and directed illegal settings, which exercise only the refusal path. The flash model changes `dq_in` only while `sck` is low, so every sampled value is stable at its rising edge.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

  localparam int LINES = 4;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_ADR  = 3'd2,
    PH_DUM  = 3'd3,
    PH_DAT  = 3'd4
  } phase_e;

  localparam logic [1:0] LM_SINGLE = 2'd0;
  localparam logic [1:0] LM_DUAL   = 2'd1;
  localparam logic [1:0] LM_QUAD   = 2'd2;
  localparam logic [1:0] LM_RSVD   = 2'd3;

  // bits moved per serial clock for a line-width code
  function automatic int unsigned lanes_of(input logic [1:0] m);
    case (m)
      LM_DUAL: return 2;
      LM_QUAD: return 4;
      default: return 1;
    endcase
  endfunction

  // serial clocks needed to move nbits at a line-width code
  function automatic int unsigned steps_for(input int unsigned nbits, input logic [1:0] m);
    return nbits / lanes_of(m);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned r;
    r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    if (d > r) r = d;
    return r;
  endfunction

endpackage

// File: rtl/qspi_cfg_check.sv
module qspi_cfg_check #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] dum_len,
  input  logic [CNT_W-1:0] drv_len,
  input  logic [1:0]       adr_mode,
  input  logic [1:0]       dum_mode,
  input  logic [1:0]       dat_mode,
  output logic             cfg_ok
);
  import qspi_rd_pkg::*;

  logic len_ok;
  logic mode_ok;

  assign len_ok  = (dum_len != '0) && (drv_len <= dum_len);
  assign mode_ok = (adr_mode != LM_RSVD) && (dum_mode != LM_RSVD) && (dat_mode != LM_RSVD);
  assign cfg_ok  = len_ok && mode_ok;

endmodule

// File: rtl/qspi_lane_mux.sv
module qspi_lane_mux (
  input  qspi_rd_pkg::phase_e phase,
  input  logic [1:0]          mode,
  input  logic [3:0]          tx_top,
  input  logic                drive_on,
  output logic [3:0]          dq_out,
  output logic [3:0]          dq_oe
);
  import qspi_rd_pkg::*;

  always_comb begin
    dq_out = 4'b1100;
    dq_oe  = 4'b1100;
    case (phase)
      PH_CMD: begin
        dq_out = {3'b110, tx_top[3]};
        dq_oe  = 4'b1101;
      end
      PH_ADR: begin
        case (mode)
          LM_QUAD: begin dq_out = tx_top;                 dq_oe = 4'b1111; end
          LM_DUAL: begin dq_out = {2'b11, tx_top[3:2]};   dq_oe = 4'b1111; end
          default: begin dq_out = {3'b110, tx_top[3]};    dq_oe = 4'b1101; end
        endcase
      end
      PH_DUM: begin
        dq_out = 4'b1111;
        case (mode)
          LM_QUAD: dq_oe = drive_on ? 4'b1111 : 4'b0000;
          LM_DUAL: dq_oe = drive_on ? 4'b1111 : 4'b1100;
          default: dq_oe = drive_on ? 4'b1101 : 4'b1100;
        endcase
      end
      PH_DAT: begin
        dq_oe = (mode == LM_QUAD) ? 4'b0000 : 4'b1100;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/qspi_rx_gather.sv
module qspi_rx_gather #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [3:0]        dq_in,
  output logic [DATA_W-1:0] word
);
  import qspi_rd_pkg::*;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] w,
                                                 input logic [1:0] m,
                                                 input logic [3:0] d);
    case (m)
      LM_QUAD: return {w[DATA_W-5:0], d};
      LM_DUAL: return {w[DATA_W-3:0], d[1:0]};
      default: return {w[DATA_W-2:0], d[1]};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word <= '0;
    else if (clr) word <= '0;
    else if (en)  word <= shift_in(word, mode, dq_in);
  end

endmodule

// File: rtl/qspi_rd_seq.sv
module qspi_rd_seq #(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [OP_W-1:0]   opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  dum_len,
  input  logic [CNT_W-1:0]  drv_len,
  input  logic [1:0]        adr_mode,
  input  logic [1:0]        dum_mode,
  input  logic [1:0]        dat_mode,
  input  logic [3:0]        dq_in,
  output logic              cfg_err,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              sck,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe
);
  import qspi_rd_pkg::*;

  localparam int TX_W   = OP_W + ADDR_W;
  localparam int MAXS   = max4(OP_W, ADDR_W, DATA_W, 2 ** CNT_W);
  localparam int STEP_W = $clog2(MAXS);

  phase_e              phase_q;
  logic                half_q;        // 0: sck low half, 1: sck high half
  logic [STEP_W-1:0]   cnt_q;         // serial clocks left in phase, minus one
  logic [TX_W-1:0]     tx_q;
  logic [CNT_W-1:0]    dum_len_q, drv_len_q;
  logic [1:0]          am_q, dm_q, tm_q;

  // named internal events
  logic                cfg_ok;
  logic                accept;
  logic                step_end;
  logic                phase_last;
  logic [1:0]          cur_mode;
  logic [CNT_W-1:0]    dum_idx;
  logic                drive_on;
  logic                upper_free;
  logic                rx_en;

  qspi_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .dum_len  (dum_len),
    .drv_len  (drv_len),
    .adr_mode (adr_mode),
    .dum_mode (dum_mode),
    .dat_mode (dat_mode),
    .cfg_ok   (cfg_ok)
  );

  assign accept     = (phase_q == PH_IDLE) && req && cfg_ok;
  assign step_end   = (phase_q != PH_IDLE) && half_q;
  assign phase_last = (cnt_q == '0);

  always_comb begin
    case (phase_q)
      PH_ADR:  cur_mode = am_q;
      PH_DUM:  cur_mode = dm_q;
      PH_DAT:  cur_mode = tm_q;
      default: cur_mode = LM_SINGLE;
    endcase
  end

  assign dum_idx    = dum_len_q - cnt_q[CNT_W-1:0];
  assign drive_on   = (phase_q == PH_DUM) && (dum_idx <= drv_len_q);
  assign upper_free = (cur_mode != LM_QUAD);
  assign rx_en      = step_end && (phase_q == PH_DAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      half_q    <= 1'b0;
      cnt_q     <= '0;
      tx_q      <= '0;
      dum_len_q <= '0;
      drv_len_q <= '0;
      am_q      <= LM_SINGLE;
      dm_q      <= LM_SINGLE;
      tm_q      <= LM_SINGLE;
      done      <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      done    <= 1'b0;
      cfg_err <= 1'b0;
      if (phase_q == PH_IDLE) begin
        half_q <= 1'b0;
        if (accept) begin
          phase_q   <= PH_CMD;
          cnt_q     <= STEP_W'(OP_W - 1);
          tx_q      <= {opcode, addr};
          dum_len_q <= dum_len;
          drv_len_q <= drv_len;
          am_q      <= adr_mode;
          dm_q      <= dum_mode;
          tm_q      <= dat_mode;
        end else if (req) begin
          cfg_err <= 1'b1;
        end
      end else begin
        half_q <= ~half_q;
        if (step_end) begin
          if (!phase_last) cnt_q <= cnt_q - 1'b1;
          case (phase_q)
            PH_CMD: begin
              tx_q <= tx_q << 1;
              if (phase_last) begin
                phase_q <= PH_ADR;
                cnt_q   <= STEP_W'(steps_for(ADDR_W, am_q) - 1);
              end
            end
            PH_ADR: begin
              tx_q <= tx_q << lanes_of(am_q);
              if (phase_last) begin
                phase_q <= PH_DUM;
                cnt_q   <= STEP_W'(dum_len_q);
              end
            end
            PH_DUM: begin
              if (phase_last) begin
                phase_q <= PH_DAT;
                cnt_q   <= STEP_W'(steps_for(DATA_W, tm_q) - 1);
              end
            end
            PH_DAT: begin
              if (phase_last) begin
                phase_q <= PH_IDLE;
                done    <= 1'b1;
              end
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign cs_n = (phase_q == PH_IDLE);
  assign sck  = half_q && (phase_q != PH_IDLE);

  qspi_lane_mux u_mux (
    .phase    (phase_q),
    .mode     (cur_mode),
    .tx_top   (tx_q[TX_W-1 -: 4]),
    .drive_on (drive_on),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  qspi_rx_gather #(.DATA_W(DATA_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (rx_en),
    .mode  (tm_q),
    .dq_in (dq_in),
    .word  (rdata)
  );

endmodule

// File: rtl/qspi_rd_seq_chk.sv
module qspi_rd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       done,
  input logic       cfg_err,
  input logic [3:0] dq_out,
  input logic [3:0] dq_oe,
  input logic       upper_free
);

  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);  // R2

  AST_SCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> (sck != $past(sck)));  // R2

  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (cs_n && !done));  // R1

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);  // R1

  AST_UPPER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    upper_free |-> (dq_oe[3:2] == 2'b11 && dq_out[3:2] == 2'b11));  // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9

  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));  // R9

endmodule

bind qspi_rd_seq qspi_rd_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sck        (sck),
  .done       (done),
  .cfg_err    (cfg_err),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .upper_free (upper_free)
);

// File: tb/qspi_rd_seq_tb.sv
`timescale 1ns/1ps
module qspi_rd_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  opcode = '0;
  logic [23:0] addr = '0;
  logic [3:0]  dum_len = 4'd1, drv_len = '0;
  logic [1:0]  adr_mode = '0, dum_mode = '0, dat_mode = '0;
  logic [3:0]  dq_in = '0;
  logic        cfg_err, done, cs_n, sck;
  logic [31:0] rdata;
  logic [3:0]  dq_out, dq_oe;

  always #4 clk = ~clk;  // 125 MHz

  qspi_rd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .opcode(opcode), .addr(addr),
    .dum_len(dum_len), .drv_len(drv_len), .adr_mode(adr_mode),
    .dum_mode(dum_mode), .dat_mode(dat_mode), .dq_in(dq_in),
    .cfg_err(cfg_err), .done(done), .rdata(rdata), .cs_n(cs_n), .sck(sck),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int fails  = 0;

  logic [3:0]  rec_out [0:127];
  logic [3:0]  rec_oe  [0:127];
  int          nsteps = 0;
  logic [31:0] flash_word = '0;
  int          flash_ld = 1;
  int          data_start = 1000;

  function automatic int nl(input logic [1:0] m);
    return (m == 2'd2) ? 4 : (m == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic [3:0] lane_mask(input int l);
    return (l == 4) ? 4'b1111 : (l == 2) ? 4'b0011 : 4'b0001;
  endfunction

  function automatic logic [3:0] chunk_of(input logic [31:0] w, input int l, input int j);
    logic [31:0] t;
    t = w >> (32 - l * (j + 1));
    return t[3:0] & lane_mask(l);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // step recorder and flash model
  always @(negedge clk) begin
    if (!cs_n && sck) begin
      if (nsteps < 128) begin
        rec_out[nsteps] = dq_out;
        rec_oe[nsteps]  = dq_oe;
      end
      nsteps = nsteps + 1;
    end else if (!cs_n && !sck) begin
      if (nsteps >= data_start) begin
        logic [3:0] c;
        logic [3:0] v;
        c = chunk_of(flash_word, flash_ld, nsteps - data_start);
        v = 4'($urandom);
        if (flash_ld == 1) v[1] = c[0];
        else if (flash_ld == 2) v[1:0] = c[1:0];
        else v = c;
        dq_in = v;
      end else begin
        dq_in = 4'($urandom);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic bad_req(input logic [3:0] dl, input logic [3:0] dr, input logic [1:0] am,
                         input logic [1:0] dm, input logic [1:0] tm);
    @(negedge clk);
    dum_len = dl; drv_len = dr; adr_mode = am; dum_mode = dm; dat_mode = tm;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(cfg_err && cs_n && !sck, "R1 error strobe, no start", {cfg_err, cs_n, sck}, 3'b110);
    @(negedge clk);
    check(!cfg_err && cs_n && !sck, "R1 strobe one cycle, still idle", {cfg_err, cs_n, sck}, 3'b010);
  endtask

  task automatic run_txn(input logic [7:0] op, input logic [23:0] ad, input logic [3:0] dl,
                         input logic [3:0] dr, input logic [1:0] am, input logic [1:0] dm,
                         input logic [1:0] tm, input logic [31:0] w);
    int la, ld, na, nd, ndum, exp_steps, cyc, e_cmd, e_adr, e_dum, e_dat, e_up;
    logic [23:0] acc;
    la = nl(am); ld = nl(tm);
    na = 24 / la; nd = 32 / ld; ndum = int'(dl) + 1;
    exp_steps = 8 + na + ndum + nd;
    @(negedge clk);
    opcode = op; addr = ad; dum_len = dl; drv_len = dr;
    adr_mode = am; dum_mode = dm; dat_mode = tm;
    flash_word = w; flash_ld = ld; data_start = 8 + na + ndum;
    nsteps = 0;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(!cs_n && !sck, "R2 cs_n low before first sck edge", {cs_n, sck}, 2'b00);
    // R10: disturb inputs after capture
    opcode = 8'($urandom); addr = 24'($urandom); dum_len = 4'd0; drv_len = 4'hf;
    adr_mode = 2'd3; dum_mode = 2'($urandom); dat_mode = 2'($urandom);
    @(negedge clk);
    check(!cs_n && sck, "R2 sck rises on next cycle", {cs_n, sck}, 2'b01);
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check(done && cs_n, "R9 done with cs_n released", {done, cs_n}, 2'b11);
    check(rdata == w, "R7 read word", rdata, w);
    check(nsteps == exp_steps, "R5 serial clock count", nsteps, exp_steps);
    @(negedge clk);
    check(!done && cs_n, "R9 done one cycle", {done, cs_n}, 2'b01);
    repeat (3) @(negedge clk);
    check(cs_n && !cfg_err, "R10 stray req started nothing", {cs_n, cfg_err}, 2'b10);
    if (nsteps != exp_steps) return;
    // R3 command phase
    e_cmd = 0;
    for (int s = 0; s < 8; s++)
      if (rec_out[s][0] != op[7 - s] || rec_oe[s][1:0] != 2'b01) e_cmd++;
    check(e_cmd == 0, "R3 opcode on line 0", e_cmd, 0);
    // R4 address phase
    acc = '0; e_adr = 0;
    for (int s = 0; s < na; s++) begin
      acc = (acc << la) | 24'(rec_out[8 + s] & lane_mask(la));
      if ((rec_oe[8 + s] & lane_mask(la)) != lane_mask(la)) e_adr++;
    end
    check(acc == ad && e_adr == 0, "R4 address bits", acc, ad);
    // R6 dummy drive window
    e_dum = 0;
    for (int d = 0; d < ndum; d++) begin
      logic [3:0] m, o, e;
      m = lane_mask(nl(dm)); o = rec_oe[8 + na + d]; e = rec_out[8 + na + d];
      if (d <= int'(dr)) begin
        if ((o & m) != m || (e & m) != m) e_dum++;
      end else if ((o & m) != 4'b0000) e_dum++;
    end
    check(e_dum == 0, "R6 dummy drive then release", e_dum, 0);
    // R7 data lines released
    e_dat = 0;
    for (int s = 0; s < nd; s++)
      if ((rec_oe[data_start + s] & (ld == 4 ? 4'b1111 : 4'b0011)) != 4'b0000) e_dat++;
    check(e_dat == 0, "R7 data lines not driven", e_dat, 0);
    // R8 upper lines held high outside quad phases
    e_up = 0;
    for (int s = 0; s < exp_steps; s++) begin
      logic [1:0] pm;
      if (s < 8) pm = 2'd0;
      else if (s < 8 + na) pm = am;
      else if (s < data_start) pm = dm;
      else pm = tm;
      if (pm != 2'd2 && (rec_oe[s][3:2] != 2'b11 || rec_out[s][3:2] != 2'b11)) e_up++;
    end
    check(e_up == 0, "R8 lines 3..2 held high", e_up, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !sck && !done && !cfg_err, "R2 reset idle", {cs_n, sck, done, cfg_err}, 4'b1000);
    check(dq_oe == 4'b1100 && dq_out[3:2] == 2'b11, "R8 reset line state", {dq_oe, dq_out}, 8'hcc);

    // directed corners
    run_txn(8'h6b, 24'h123456, 4'd1,  4'd0,  2'd0, 2'd0, 2'd0, 32'hdeadbeef);
    run_txn(8'heb, 24'habcdef, 4'd15, 4'd15, 2'd2, 2'd2, 2'd2, 32'h0f1e2d3c);
    run_txn(8'h3b, 24'hfedcba, 4'd15, 4'd0,  2'd1, 2'd1, 2'd1, 32'h80000001);
    run_txn(8'h0b, 24'h000001, 4'd7,  4'd3,  2'd0, 2'd2, 2'd1, 32'hffffffff);
    run_txn(8'hbb, 24'h800000, 4'd2,  4'd2,  2'd2, 2'd0, 2'd0, 32'h00000000);

    // illegal configurations
    bad_req(4'd0, 4'd0, 2'd0, 2'd0, 2'd0);
    bad_req(4'd3, 4'd4, 2'd1, 2'd1, 2'd1);
    bad_req(4'd5, 4'd1, 2'd3, 2'd0, 2'd0);
    bad_req(4'd5, 4'd1, 2'd0, 2'd3, 2'd0);
    bad_req(4'd5, 4'd1, 2'd0, 2'd0, 2'd3);

    // constrained random
    for (int i = 0; i < 25; i++) begin
      logic [3:0] dl, dr;
      dl = 4'(1 + ($urandom % 15));
      dr = 4'($urandom % (int'(dl) + 1));
      run_txn(8'($urandom), 24'($urandom), dl, dr, 2'($urandom % 3), 2'($urandom % 3),
              2'($urandom % 3), $urandom);
    end

    finish_run();
  end

endmodule